// File: doc/BRIEF.md
# Parallel Prefix Adder

This block is a purely combinational N-bit binary adder. It takes two N-bit operands and a single carry input, and it returns an N-bit sum and a carry output. The width N must be a power of two and defaults to 16. Instead of passing the carry from bit to bit, the adder computes every column's incoming carry through a tree of generate/propagate merge cells. The tree is logarithmic in depth.

The carry input is handled as an extra, lowest column that sits below bit 0. That column always generates the carry value and never propagates. Because of this, every group that reaches down to it resolves to a plain generate term, and that term is the carry into the column above the group. Each tree level doubles the span covered by a column. After log2(N) levels, every sum bit has its incoming carry. One more merge cell combines the top column's group with the carry-input column to form the carry output. The block is meant to be used wherever a wide, shallow, carry-complete adder is needed inside a larger datapath.

Top module: `prefix_adder`

## Requirements
- R1: For every pair of operands and either carry input, {cout, sum} equals opa + opb + cin, taken as an unsigned (N+1)-bit value.
- R2: The carry input enters as a column below bit 0, so sum bit 0 equals opa[0] XOR opb[0] XOR cin.
- R3: When every bit pair differs (opa XOR opb is all ones), the carry input travels through all N columns: every sum bit equals NOT cin, and cout equals cin.
- R4: When opa[N-1] and opb[N-1] are both 1, cout is 1, whatever the lower bits and cin are.
- R5: When opa[N-1] and opb[N-1] are both 0, cout is 0, whatever the lower bits and cin are.
- R6: The same structure is built correctly for other power-of-two widths. With N = 4, all 512 combinations of operands and carry input satisfy R1.
- R7: After log2(N) tree levels, every group that starts at a sum column and reaches the carry-input column has a group propagate of 0. Every sum bit therefore reads a fully resolved carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| cin | input | 1 | Carry input, treated as the column below bit 0 |
| sum | output | N | Low N bits of opa + opb + cin |
| cout | output | 1 | Carry out of the top column |

## Verification
At N = 4 every input combination is applied, which rules out any wiring slip in a small tree. At N = 16, seeded random operands show that merge cells across all levels combine spans correctly. Several directed patterns are added:
- All-propagate operands with each carry input. These exercise the longest carry path and separate a correct merge from one that drops the propagate term.
- Operands whose top columns generate or kill. These separate a correct carry output from one taken off the wrong group.
- A single generated carry at bit 0 under a chain of propagates. This confirms that carries reach the top through every level of the tree.

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int STAGES = $clog2(N);
  localparam int COLS   = N + 1;

  // column index 0 holds the carry input; index i+1 holds operand bit i
  wire [COLS-1:0] gv [0:STAGES];
  wire [COLS-1:0] pv [0:STAGES];

  assign gv[0][0] = cin;
  assign pv[0][0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_col
    assign gv[0][i+1] = opa[i] & opb[i];
    assign pv[0][i+1] = opa[i] ^ opb[i];
  end

  for (genvar lv = 1; lv <= STAGES; lv++) begin : g_lvl
    localparam int DIST = 1 << (lv - 1);
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      if (c >= DIST) begin : g_merge
        assign gv[lv][c] = gv[lv-1][c] | (pv[lv-1][c] & gv[lv-1][c-DIST]);
        assign pv[lv][c] = pv[lv-1][c] & pv[lv-1][c-DIST];
      end else begin : g_pass
        assign gv[lv][c] = gv[lv-1][c];
        assign pv[lv][c] = pv[lv-1][c];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_sum
    assign sum[i] = pv[0][i+1] ^ gv[STAGES][i];
  end

  assign cout = gv[STAGES][N] | (pv[STAGES][N] & gv[STAGES][0]);

  always_comb begin
    // R1
    add_value_chk: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + (N+1)'(cin)));
    // R2
    low_carry_chk: assert (sum[0] == (opa[0] ^ opb[0] ^ cin));
    // R3
    if ((opa ^ opb) == {N{1'b1}})
      full_ripple_chk: assert (sum == {N{~cin}} && cout == cin);
    // R4
    if (opa[N-1] && opb[N-1])
      top_gen_chk: assert (cout);
    // R5
    if (!opa[N-1] && !opb[N-1])
      top_kill_chk: assert (!cout);
    // R7
    resolved_chk: assert (pv[STAGES][N-1:0] == '0);
  end
endmodule

// File: tb/prefix_adder_bench.sv
module prefix_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [WS-1:0] as, bs, ss;
  logic          cis, cos;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  prefix_adder #(.N(W)) u_prefix_adder (.opa(a), .opb(b), .cin(ci), .sum(s), .cout(co));
  prefix_adder #(.N(WS)) u_prefix_adder_n4 (.opa(as), .opb(bs), .cin(cis), .sum(ss), .cout(cos));

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [WS:0] ref_add4(logic [WS-1:0] x, logic [WS-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{WS{1'b0}}, c};
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, ci);
    end
  endtask

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic c);
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
  endtask

  task automatic run_full(string req, logic [W-1:0] x, logic [W-1:0] y, logic c);
    drive(x, y, c);
    check(req, {co, s}, ref_add(x, y, c));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y;
    void'($urandom(32'h5eed_0a11));
    a = '0; b = '0; ci = 1'b0;
    as = '0; bs = '0; cis = 1'b0;

    // R1: zero operands
    drive('0, '0, 1'b0);
    check("R1", {co, s}, '0);

    // R3: every column propagates; carry must cross the whole width
    run_full("R3", 16'hFFFF, 16'h0000, 1'b1);
    check("R3", {co, s}, {1'b1, 16'h0000});
    run_full("R3", 16'hAAAA, 16'h5555, 1'b0);
    check("R3", {co, s}, {1'b0, 16'hFFFF});
    run_full("R3", 16'h0F0F, 16'hF0F0, 1'b1);
    check("R3", {co, s}, {1'b1, 16'h0000});

    // R1: single carry generated at bit 0 rides a propagate chain
    run_full("R1", 16'h7FFF, 16'h0001, 1'b0);
    check("R1", {co, s}, {1'b0, 16'h8000});
    run_full("R1", 16'hFFFF, 16'h0001, 1'b0);
    check("R1", {co, s}, {1'b1, 16'h0000});
    run_full("R1", 16'hFFFF, 16'hFFFF, 1'b1);

    // R2: bit 0 takes cin as its carry
    for (int k = 0; k < 8; k++) begin
      x = 16'($urandom); y = 16'($urandom);
      drive(x, y, k[0]);
      check("R2", {16'b0, s[0]}, {16'b0, x[0] ^ y[0] ^ k[0]});
    end

    // R4 / R5: top column generates or kills
    for (int k = 0; k < 16; k++) begin
      x = 16'($urandom); y = 16'($urandom);
      x[W-1] = 1'b1; y[W-1] = 1'b1;
      drive(x, y, k[0]);
      check("R4", {16'b0, co}, {16'b0, 1'b1});
      x[W-1] = 1'b0; y[W-1] = 1'b0;
      drive(x, y, k[1]);
      check("R5", {16'b0, co}, {16'b0, 1'b0});
    end

    // R1 and R7: random vectors
    for (int k = 0; k < 3000; k++) begin
      x = 16'($urandom); y = 16'($urandom);
      run_full("R1", x, y, 1'($urandom));
    end

    // R6: exhaustive at width 4
    for (int xi = 0; xi < 16; xi++) begin
      for (int yi = 0; yi < 16; yi++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          as = 4'(xi); bs = 4'(yi); cis = c[0];
          #1;
          checks++;
          if ({cos, ss} !== ref_add4(4'(xi), 4'(yi), c[0])) begin
            failures++;
            $display("FAIL R6 actual=%h expected=%h", {cos, ss}, ref_add4(4'(xi), 4'(yi), c[0]));
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule